// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Zero and Carry Flags

This block is the execution unit of a small two-operand load-store processor. Each operation takes the destination register value and a second operand, which is either a second register value or an 8-bit immediate. It also takes an operation code and the present zero and carry flags. It returns the result, a write-enable for the destination register and the next values of both flags. The unit covers add and subtract with or without carry/borrow, compare, test, AND/OR/XOR, rotates by one bit (plain and through carry), and direct set/clear of each flag.

Operations arrive over a valid/ready stream and leave through one output register stage that also uses valid/ready. An operation is accepted on a rising clock edge where `op_valid` and `op_ready` are both high. Its result is presented on the next cycle and held there until the consumer takes it with `res_ready`. `op_ready` is high whenever the output stage is empty or is being drained in the same cycle, so the stage can take one operation per cycle without stalling. Back-pressure on the result side stalls the input side in the same cycle.

Top module: `alu_byte_core`

## Requirements
- R1: ADD (code 0) returns a+b and ADDC (code 1) returns a+b+carry_in. Each takes carry from the ninth bit of the sum and writes the result back.
- R2: SUB (code 2) returns a-b and SUBB (code 3) returns a-b-carry_in. Carry is set exactly when the unsigned subtraction underflows, and the result is written back.
- R3: CMP (code 4) computes and flags exactly as SUB but never asserts the write-enable.
- R4: AND (code 5), OR (code 6) and XOR (code 7) write back their result and update only the zero flag. TEST (code 8) is an AND without write-back. Carry passes through unchanged for all four.
- R5: For every operation with code 0 to 12, the zero flag is set exactly when the 8-bit result is zero.
- R6: ROL (code 9) rotates left by one with bit 7 wrapping into bit 0. ROR (code 10) rotates right with bit 0 wrapping into bit 7. Each copies the bit that left the byte into carry and writes back.
- R7: RLC (code 11) shifts left with carry_in entering bit 0 and bit 7 going to carry. RRC (code 12) shifts right with carry_in entering bit 7 and bit 0 going to carry. Clearing carry and then using RLC therefore gives a logical left shift.
- R8: SETC (13) and CLRC (14) force carry to 1 and 0. SETZ (15) and CLRZ (16) force zero to 1 and 0. Each keeps the other flag and never writes back.
- R9: When `op_use_imm` is 1 the second operand is `op_imm`, otherwise `op_src`. Every operation uses the same datapath for both forms.
- R10: Codes 17 to 31 are reserved: no write-back, and both flags equal the incoming flags.
- R11: An operation is accepted when `op_valid` and `op_ready` are both high, and its outputs appear with `res_valid` on the following cycle. `op_ready` is low while `res_valid` is high and `res_ready` is low. During such a stall every result output holds its value.
- R12: After reset `res_valid` is 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present on the input side |
| op_ready | output | 1 | Unit can accept an operation this cycle |
| op_code | input | 5 | Operation select (codes in R1 to R10) |
| op_dst | input | 8 | Destination register value (operand a) |
| op_src | input | 8 | Second register value |
| op_imm | input | 8 | Immediate constant |
| op_use_imm | input | 1 | 1 selects the immediate as operand b |
| op_carry | input | 1 | Present carry flag |
| op_zero | input | 1 | Present zero flag |
| res_valid | output | 1 | Result present on the output side |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 8 | Result value |
| res_wr | output | 1 | Write the result to the destination register |
| res_zero | output | 1 | Next zero flag |
| res_carry | output | 1 | Next carry flag |

## Verification
The hardest situation to reach from the ports is a stall with a second operation waiting. The output register must then hold one result while `op_ready` is low, and take the next operation on the same edge that the consumer releases the stall. The stimulus holds `res_ready` low and issues one operation. It then offers a second operation with different operands for several cycles, checks that the first result stays put and that `op_ready` stays low, and raises `res_ready` to confirm that the second result appears one cycle later. The borrow corners also take deliberate operands: zero minus zero with borrow set, and 0xFF plus 0x01.

// File: rtl/alu_byte_pkg.sv
package alu_byte_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBB = 5'd3,
    OP_CMP  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_TEST = 5'd8,
    OP_ROL  = 5'd9,
    OP_ROR  = 5'd10,
    OP_RLC  = 5'd11,
    OP_RRC  = 5'd12,
    OP_SETC = 5'd13,
    OP_CLRC = 5'd14,
    OP_SETZ = 5'd15,
    OP_CLRZ = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu_byte_addsub.sv
module alu_byte_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         is_sub,
  input  logic         use_cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  // Subtraction is a + ~b + 1, less one more when a borrow is pending.
  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   wide;

  always_comb begin
    b_eff = is_sub ? ~b : b;
    if (is_sub) c0 = use_cin ? ~cin : 1'b1;
    else        c0 = use_cin ?  cin : 1'b0;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    sum   = wide[W-1:0];
    // For subtraction a missing carry out means the result underflowed.
    cout  = is_sub ? ~wide[W] : wide[W];
  end
endmodule

// File: rtl/alu_byte_logic.sv
module alu_byte_logic
  import alu_byte_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/alu_byte_rotate.sv
module alu_byte_rotate #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         right,
  input  logic         thru,
  output logic [W-1:0] y,
  output logic         cout
);
  logic fill_l, fill_r;

  always_comb begin
    fill_l = thru ? cin : a[W-1];
    fill_r = thru ? cin : a[0];
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
        assign y[i] = right ? a[i+1] : fill_l;
      end else if (i == W-1) begin : g_hi
        assign y[i] = right ? fill_r : a[i-1];
      end else begin : g_mid
        assign y[i] = right ? a[i+1] : a[i-1];
      end
    end
  endgenerate

  assign cout = right ? a[0] : a[W-1];
endmodule

// File: rtl/alu_byte_core.sv
module alu_byte_core
  import alu_byte_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   op_dst,
  input  logic [W-1:0]   op_src,
  input  logic [W-1:0]   op_imm,
  input  logic           op_use_imm,
  input  logic           op_carry,
  input  logic           op_zero,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [W-1:0]   res_data,
  output logic           res_wr,
  output logic           res_zero,
  output logic           res_carry
);
  logic [W-1:0] opb;
  logic         take;

  // Shared operand path for register and immediate forms.
  assign opb = op_use_imm ? op_imm : op_src;

  logic         as_sub, as_cin;
  logic [W-1:0] as_sum;
  logic         as_cout;

  always_comb begin
    as_sub = (op_code == OP_SUB) || (op_code == OP_SUBB) || (op_code == OP_CMP);
    as_cin = (op_code == OP_ADDC) || (op_code == OP_SUBB);
  end

  alu_byte_addsub #(.W(W)) u_addsub (
    .a(op_dst), .b(opb), .cin(op_carry), .is_sub(as_sub), .use_cin(as_cin),
    .sum(as_sum), .cout(as_cout)
  );

  logic_sel_e   lg_sel;
  logic [W-1:0] lg_y;

  always_comb begin
    unique case (op_code)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_byte_logic #(.W(W)) u_logic (
    .a(op_dst), .b(opb), .sel(lg_sel), .y(lg_y)
  );

  logic         rt_right, rt_thru;
  logic [W-1:0] rt_y;
  logic         rt_cout;

  always_comb begin
    rt_right = (op_code == OP_ROR) || (op_code == OP_RRC);
    rt_thru  = (op_code == OP_RLC) || (op_code == OP_RRC);
  end

  alu_byte_rotate #(.W(W)) u_rot (
    .a(op_dst), .cin(op_carry), .right(rt_right), .thru(rt_thru),
    .y(rt_y), .cout(rt_cout)
  );

  logic [W-1:0] n_data;
  logic         n_wr, n_zero, n_carry;

  always_comb begin
    n_data  = op_dst;
    n_wr    = 1'b0;
    n_zero  = op_zero;
    n_carry = op_carry;
    case (op_code)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        n_data = as_sum;  n_wr = 1'b1; n_carry = as_cout; n_zero = (as_sum == '0);
      end
      OP_CMP: begin
        n_data = as_sum;  n_carry = as_cout; n_zero = (as_sum == '0);
      end
      OP_AND, OP_OR, OP_XOR: begin
        n_data = lg_y;    n_wr = 1'b1; n_zero = (lg_y == '0);
      end
      OP_TEST: begin
        n_data = lg_y;    n_zero = (lg_y == '0);
      end
      OP_ROL, OP_ROR, OP_RLC, OP_RRC: begin
        n_data = rt_y;    n_wr = 1'b1; n_carry = rt_cout; n_zero = (rt_y == '0);
      end
      OP_SETC: n_carry = 1'b1;
      OP_CLRC: n_carry = 1'b0;
      OP_SETZ: n_zero  = 1'b1;
      OP_CLRZ: n_zero  = 1'b0;
      default: ;
    endcase
  end

  // Output stage: one entry, drained and refilled in the same cycle.
  assign op_ready = !res_valid || res_ready;
  assign take     = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_wr    <= 1'b0;
      res_zero  <= 1'b0;
      res_carry <= 1'b0;
    end else begin
      if (take) begin
        res_valid <= 1'b1;
        res_data  <= n_data;
        res_wr    <= n_wr;
        res_zero  <= n_zero;
        res_carry <= n_carry;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_byte_chk.sv
module alu_byte_chk
  import alu_byte_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic           op_ready,
  input logic [OPW-1:0] op_code,
  input logic           op_carry,
  input logic           op_zero,
  input logic           res_valid,
  input logic           res_ready,
  input logic [W-1:0]   res_data,
  input logic           res_wr,
  input logic           res_zero,
  input logic           res_carry
);
  logic acc;
  assign acc = op_valid && op_ready;

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_code == OP_CMP) |=> (res_valid && !res_wr));

  assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR || op_code == OP_TEST))
    |=> (res_carry == $past(op_carry)));

  assert_zero_tracks_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_code <= OP_RRC) |=> (res_zero == (res_data == '0)));

  assert_flag_ops_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_code >= OP_SETC && op_code <= OP_CLRZ) |=> !res_wr);

  assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_code > OP_CLRZ)
    |=> (!res_wr && res_carry == $past(op_carry) && res_zero == $past(op_zero)));

  assert_stall_blocks_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_wr)
                                   && $stable(res_zero) && $stable(res_carry)));
endmodule

bind alu_byte_core alu_byte_chk #(.W(W)) u_chk (.*);

// File: tb/alu_byte_core_tb.sv
module alu_byte_core_tb;
  import alu_byte_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [4:0] op_code = '0;
  logic [7:0] op_dst = '0, op_src = '0, op_imm = '0;
  logic       op_use_imm = 1'b0, op_carry = 1'b0, op_zero = 1'b0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [7:0] res_data;
  logic       res_wr, res_zero, res_carry;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  alu_byte_core u_dut (.*);

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  task automatic check(string rq, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {data,wr,z,c}=%h expected %h", rq, act, exp);
    end
  endtask

  task automatic check1(string rq, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  // Issue one operation with res_ready high and compare the outputs the next cycle.
  task automatic run_op(string rq, logic [4:0] code, logic [7:0] a, logic [7:0] b,
                        logic ci, logic zi, logic [7:0] e_data, logic e_wr,
                        logic e_z, logic e_c);
    @(negedge clk);
    op_code = code; op_dst = a; op_src = b; op_imm = ~b; op_use_imm = 1'b0;
    op_carry = ci; op_zero = zi; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check1({rq, " valid"}, res_valid, 1'b1);
    check(rq, {res_data, res_wr, res_zero, res_carry}, {e_data, e_wr, e_z, e_c});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R12 res_valid", res_valid, 1'b0);
    check1("R12 op_ready", op_ready, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run_op("R1 add",        OP_ADD,  8'h12, 8'h34, 1'b1, 1'b0, 8'h46, 1, 0, 0);
    run_op("R1 add wrap",   OP_ADD,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1, 1, 1);
    run_op("R1 addc",       OP_ADDC, 8'h7F, 8'h80, 1'b1, 1'b0, 8'h00, 1, 1, 1);
    run_op("R1 addc c0",    OP_ADDC, 8'h10, 8'h20, 1'b0, 1'b1, 8'h30, 1, 0, 0);
  endtask

  task automatic t_sub();
    run_op("R2 sub",        OP_SUB,  8'h50, 8'h20, 1'b1, 1'b0, 8'h30, 1, 0, 0);
    run_op("R2 sub borrow", OP_SUB,  8'h05, 8'h07, 1'b0, 1'b0, 8'hFE, 1, 0, 1);
    run_op("R2 subb",       OP_SUBB, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 1, 0, 1);
    run_op("R2 subb zero",  OP_SUBB, 8'h08, 8'h07, 1'b1, 1'b0, 8'h00, 1, 1, 0);
    run_op("R3 cmp equal",  OP_CMP,  8'h42, 8'h42, 1'b1, 1'b0, 8'h00, 0, 1, 0);
    run_op("R3 cmp less",   OP_CMP,  8'h01, 8'h02, 1'b0, 1'b1, 8'hFF, 0, 0, 1);
  endtask

  task automatic t_logic();
    run_op("R4 and",        OP_AND,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 1, 0, 1);
    run_op("R4 or",         OP_OR,   8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1, 1, 0);
    run_op("R4 xor",        OP_XOR,  8'hAA, 8'hFF, 1'b1, 1'b0, 8'h55, 1, 0, 1);
    run_op("R4 test",       OP_TEST, 8'h0F, 8'hF0, 1'b1, 1'b0, 8'h00, 0, 1, 1);
    run_op("R5 xor self",   OP_XOR,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 1, 1, 0);
  endtask

  task automatic t_rot();
    run_op("R6 rol",        OP_ROL,  8'h81, 8'h00, 1'b0, 1'b1, 8'h03, 1, 0, 1);
    run_op("R6 ror",        OP_ROR,  8'h02, 8'h00, 1'b1, 1'b1, 8'h01, 1, 0, 0);
    run_op("R7 rlc",        OP_RLC,  8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1, 1, 1);
    run_op("R7 rrc",        OP_RRC,  8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 1, 0, 1);
    // Logical shift composed as clear-carry then rotate through carry.
    run_op("R8 clrc",       OP_CLRC, 8'h41, 8'h00, 1'b1, 1'b1, 8'h41, 0, 1, 0);
    run_op("R7 shl",        OP_RLC,  8'h41, 8'h00, res_carry, 1'b0, 8'h82, 1, 0, 0);
  endtask

  task automatic t_flags();
    run_op("R8 setc",       OP_SETC, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 0, 0, 1);
    run_op("R8 setz",       OP_SETZ, 8'h33, 8'h00, 1'b1, 1'b0, 8'h33, 0, 1, 1);
    run_op("R8 clrz",       OP_CLRZ, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 0, 0, 0);
  endtask

  task automatic t_reserved();
    run_op("R10 code 17",   5'd17,   8'h12, 8'h34, 1'b1, 1'b0, 8'h12, 0, 0, 1);
    run_op("R10 code 31",   5'd31,   8'h00, 8'hFF, 1'b0, 1'b1, 8'h00, 0, 1, 0);
  endtask

  task automatic t_imm();
    @(negedge clk);
    op_code = OP_ADD; op_dst = 8'h10; op_src = 8'h01; op_imm = 8'h20;
    op_use_imm = 1'b1; op_carry = 1'b0; op_zero = 1'b0; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; op_use_imm = 1'b0;
    check("R9 imm add", {res_data, res_wr, res_zero, res_carry}, {8'h30, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_stall();
    @(negedge clk);
    res_ready = 1'b0;
    op_code = OP_SUB; op_dst = 8'h09; op_src = 8'h04; op_use_imm = 1'b0;
    op_carry = 1'b0; op_zero = 1'b0; op_valid = 1'b1;
    @(negedge clk);
    op_code = OP_OR; op_dst = 8'hC0; op_src = 8'h03; op_carry = 1'b1;
    check1("R11 ready low in stall", op_ready, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 held", {res_data, res_wr, res_zero, res_carry}, {8'h05, 1'b1, 1'b0, 1'b0});
    check1("R11 still stalled", op_ready, 1'b0);
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 next taken", {res_data, res_wr, res_zero, res_carry}, {8'hC3, 1'b1, 1'b0, 1'b1});
    @(negedge clk);
    check1("R11 drained", res_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_rot();
    t_flags();
    t_reserved();
    t_imm();
    t_stall();
    finish_run();
  end
endmodule